// File: doc/BRIEF.md
# Halfword-to-Word Packer with Event Padding

This block takes a stream of 16-bit halfwords and joins each consecutive pair into one 32-bit word for a memory-side writer. A static order bit picks whether the first halfword of a pair lands in the upper half (bits 31..16) or the lower half (bits 15..0) of the word; bit 31 is the most significant bit. The order bit and a 2-bit filler code are captured when the first halfword of an event is accepted, and they hold until that event closes.

An end-of-event pulse closes the current event. If the event holds an odd number of halfwords, the last word is completed with a filler halfword in the second-halfword position and written out. An even or empty event adds no word. Either way, the block gives a one-cycle done pulse and clears its pairing state, so the next event starts a fresh word.

Both data ports are valid/ready. A word is transferred on a cycle where `out_valid` and `out_ready` are both high. While a word is waiting, it stays stable and is never dropped. `in_ready` falls whenever accepting a halfword would need an output slot that is still occupied. It also stays low from the cycle after an end-of-event pulse until the event has closed. `end_event`, `order_sel`, `fill_sel` and `event_done` are plain level or pulse pins without a handshake.

Top module: `halfword_packer`

## Requirements
- R1: With the event's order bit at 1, a completed pair is written as {first, second}, with the first halfword in bits 31..16.
- R2: With the event's order bit at 0, a completed pair is written as {second, first}, with the first halfword in bits 15..0.
- R3: When an event ends with an odd halfword count, one extra word is written, with the filler in the second-halfword position. The filler depends on the code: 00 gives 16'h8000, 01 gives 16'h0000, 10 gives 16'hAA55 and 11 gives 16'hFFFF.
- R4: An event with an even halfword count, or with no halfwords, writes no extra word at its end, but still gives a done pulse.
- R5: After an event closes, the next accepted halfword is the first halfword of a new word.
- R6: The order bit and the filler code are sampled in the cycle the first halfword of an event is accepted. Later changes have no effect until the event closes.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change. No halfword is accepted if completing its pair would need that busy slot.
- R8: From the cycle after `end_event`, `in_ready` is low until `event_done` pulses. `event_done` pulses once per event. It appears only when at most the event's final word is still waiting in the output slot.
- R9: A halfword accepted in the same cycle as `end_event` belongs to the event that is ending.
- R10: After reset, `out_valid` and `event_done` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Halfword offered |
| in_ready | output | 1 | Halfword can be taken this cycle |
| in_data | input | 16 | Halfword value |
| end_event | input | 1 | One-cycle pulse that closes the current event |
| order_sel | input | 1 | 1: first halfword goes high; 0: first halfword goes low |
| fill_sel | input | 2 | Filler code used for an odd-length event |
| out_valid | output | 1 | Packed word offered |
| out_ready | input | 1 | Memory side takes the word |
| out_data | output | 32 | Packed word |
| event_done | output | 1 | One-cycle pulse when an event has closed |

## Verification
Two functions can fall in the same cycle: a halfword accepted in the very cycle `end_event` is raised, and the close of that event. The bench provokes this on purpose by waiting for `in_ready` and then raising both pins together, both after a lone halfword and after one that completes a pair. It judges the result by whether the output holds a padded word or a plain pair word, and by the absence of any stray filler word. Random stalls on `out_ready` make the padding wait for a busy output slot. Random changes to the order bit and filler code during an event show whether the captured configuration really holds.

// File: rtl/hwp_pkg.sv
package hwp_pkg;
  typedef enum logic [1:0] {
    FILL_TOPBIT = 2'b00,
    FILL_ZERO   = 2'b01,
    FILL_ALT    = 2'b10,
    FILL_ONES   = 2'b11
  } fill_code_e;
endpackage

// File: rtl/hwp_fill.sv
module hwp_fill #(
  parameter int W = 16
) (
  input  logic [1:0]   code,
  output logic [W-1:0] pat
);
  import hwp_pkg::*;
  localparam int HALF = W / 2;

  always_comb begin
    pat = '0;
    case (fill_code_e'(code))
      FILL_TOPBIT: pat[W-1] = 1'b1;
      FILL_ZERO:   pat = '0;
      FILL_ALT: begin
        for (int i = 0; i < W; i++) begin
          if (i >= HALF) pat[i] = (i % 2 == 1);
          else           pat[i] = (i % 2 == 0);
        end
      end
      default:     pat = '1;
    endcase
  end
endmodule

// File: rtl/hwp_cfg.sv
module hwp_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_open,
  input  logic       ord_live,
  input  logic [1:0] fsel_live,
  output logic       ord_eff,
  output logic [1:0] fsel_eff
);
  logic       ord_q;
  logic [1:0] fsel_q;

  // Follow the live pins while no event is open; freeze once one opens.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ord_q  <= 1'b0;
      fsel_q <= 2'b00;
    end else if (!ev_open) begin
      ord_q  <= ord_live;
      fsel_q <= fsel_live;
    end
  end

  assign ord_eff  = ev_open ? ord_q  : ord_live;
  assign fsel_eff = ev_open ? fsel_q : fsel_live;

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_open && $past(ev_open)) |-> ($stable(ord_eff) && $stable(fsel_eff)));
endmodule

// File: rtl/hwp_oreg.sv
module hwp_oreg #(
  parameter int WW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WW-1:0] word,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [WW-1:0] out_data,
  output logic          slot_free
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7
  load_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> slot_free);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/hwp_pair.sv
module hwp_pair #(
  parameter int HW = 16,
  localparam int WW = 2 * HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [HW-1:0] in_data,
  output logic          in_ready,
  input  logic          eoe,
  input  logic          slot_free,
  input  logic          ord,
  input  logic [HW-1:0] pad,
  output logic          load,
  output logic [WW-1:0] word,
  output logic          ev_open,
  output logic          ev_done
);
  logic          half_q, pend_q, open_q, done_q;
  logic [HW-1:0] hold_q;
  logic          acc, pair_load, pad_load, finish;
  logic [HW-1:0] second;

  assign in_ready  = !pend_q && (!half_q || slot_free);
  assign acc       = in_valid && in_ready;
  assign pair_load = acc && half_q;
  assign finish    = pend_q && slot_free;
  assign pad_load  = finish && half_q;
  assign load      = pair_load || pad_load;
  assign second    = pad_load ? pad : in_data;
  assign word      = ord ? {hold_q, second} : {second, hold_q};
  assign ev_open   = open_q;
  assign ev_done   = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      hold_q <= '0;
      pend_q <= 1'b0;
      open_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (load)            half_q <= 1'b0;
      else if (acc)        half_q <= 1'b1;
      if (acc && !half_q)  hold_q <= in_data;
      if (finish)          open_q <= 1'b0;
      else if (acc)        open_q <= 1'b1;
      pend_q <= eoe || (pend_q && !finish);
      done_q <= finish;
    end
  end

  // R8
  eoe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoe |=> !in_ready);
  // R5
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |-> (!half_q && !open_q));
  // R3
  pad_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_load |=> ev_done);
endmodule

// File: rtl/halfword_packer.sv
module halfword_packer #(
  parameter int HW_W = 16,
  localparam int WD_W = 2 * HW_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [HW_W-1:0] in_data,
  input  logic            end_event,
  input  logic            order_sel,
  input  logic [1:0]      fill_sel,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [WD_W-1:0] out_data,
  output logic            event_done
);
  logic            ev_open, ord_eff, slot_free, load;
  logic [1:0]      fsel_eff;
  logic [HW_W-1:0] pad;
  logic [WD_W-1:0] word;

  hwp_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .ev_open(ev_open),
    .ord_live(order_sel), .fsel_live(fill_sel),
    .ord_eff(ord_eff), .fsel_eff(fsel_eff)
  );

  hwp_fill #(.W(HW_W)) u_fill (.code(fsel_eff), .pat(pad));

  hwp_pair #(.HW(HW_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .eoe(end_event), .slot_free(slot_free),
    .ord(ord_eff), .pad(pad), .load(load), .word(word),
    .ev_open(ev_open), .ev_done(event_done)
  );

  hwp_oreg #(.WW(WD_W)) u_oreg (
    .clk(clk), .rst_n(rst_n), .load(load), .word(word),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .slot_free(slot_free)
  );

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !event_done));
endmodule

// File: tb/halfword_packer_test.sv
module halfword_packer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, end_event = 1'b0, order_sel = 1'b0, out_ready = 1'b0;
  logic [15:0] in_data = '0;
  logic [1:0]  fill_sel = '0;
  logic        in_ready, out_valid, event_done;
  logic [31:0] out_data;

  halfword_packer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .end_event(end_event), .order_sel(order_sel),
    .fill_sel(fill_sel), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .event_done(event_done)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int exp_done = 0, got_done = 0, ready_pct = 70;
  logic [31:0] q[$];
  string tq[$];
  string cur_tag = "";
  logic m_open = 0, m_half = 0, m_ord = 0, waiting = 0, last_acc = 0;
  logic [1:0]  m_fsel = 0;
  logic [15:0] m_hold = 0;
  logic prev_stall = 0;
  logic [31:0] prev_data = 0;

  function automatic logic [15:0] fill_of(input logic [1:0] c);
    case (c)
      2'b00: return 16'h8000;
      2'b01: return 16'h0000;
      2'b10: return 16'hAA55;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [31:0] pk(input logic [15:0] f, input logic [15:0] s, input logic o);
    return o ? {f, s} : {s, f};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w, input string dflt);
    q.push_back(w);
    tq.push_back(cur_tag != "" ? cur_tag : dflt);
  endtask

  task automatic tick();
    logic [31:0] w;
    string t;
    #1;
    if (event_done) begin
      got_done++;
      check(got_done <= exp_done && q.size() <= 1, "R8 done pulse timing",
            q.size(), 32'd1);
      waiting = 0;
    end
    if (waiting && !event_done)
      check(!in_ready, "R8 input blocked while closing", in_ready, 0);
    if (prev_stall)
      check(out_valid && out_data == prev_data, "R7 stalled word held", out_data, prev_data);
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    if (out_valid && out_ready) begin
      if (q.size() == 0) begin
        check(1'b0, "R4 unexpected word", out_data, 0);
      end else begin
        w = q.pop_front();
        t = tq.pop_front();
        check(out_data == w, t, out_data, w);
      end
    end
    last_acc = in_valid && in_ready;
    if (last_acc) begin
      if (!m_open) begin
        m_ord = order_sel; m_fsel = fill_sel; m_open = 1;
      end
      if (!m_half) begin
        m_hold = in_data; m_half = 1;
      end else begin
        push(pk(m_hold, in_data, m_ord), m_ord ? "R1 pair order high" : "R2 pair order low");
        m_half = 0;
      end
    end
    if (end_event) begin
      if (m_half) push(pk(m_hold, fill_of(m_fsel), m_ord), "R3 filler word");
      m_half = 0; m_open = 0; exp_done++; waiting = 1;
    end
    @(posedge clk);
    @(negedge clk);
    out_ready = (($urandom % 100) < ready_pct);
    #1;
  endtask

  task automatic send_hw(input logic [15:0] d);
    in_valid = 1; in_data = d;
    do tick(); while (!last_acc);
    in_valid = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (waiting && n < 1000) begin
      tick(); n++;
    end
  endtask

  task automatic end_ev(input logic with_hw, input logic [15:0] d);
    if (with_hw) begin
      while (!in_ready) tick();
      in_valid = 1; in_data = d;
    end
    end_event = 1;
    tick();
    end_event = 0; in_valid = 0;
    wait_done();
  endtask

  task automatic drain();
    ready_pct = 100;
    repeat (4) tick();
    ready_pct = 70;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk); #1;
    repeat (3) tick();
    check(!out_valid && !event_done && in_ready, "R10 reset state",
          {out_valid, event_done, in_ready}, 32'b001);
    rst_n = 1;
    tick();
    check(!out_valid && !event_done && in_ready, "R10 after release",
          {out_valid, event_done, in_ready}, 32'b001);

    // R1 / R2 directed pairs
    order_sel = 1; send_hw(16'h1111); send_hw(16'h2222); end_ev(0, 0);
    order_sel = 0; send_hw(16'h3333); send_hw(16'h4444); end_ev(0, 0);

    // R3 each filler code, both orders
    for (int o = 0; o < 2; o++) begin
      for (int c = 0; c < 4; c++) begin
        order_sel = o[0]; fill_sel = c[1:0];
        send_hw(16'h0C00 + 16'(c)); end_ev(0, 0);
      end
    end

    // R4 empty event and even event
    drain();
    cur_tag = "R4 even event";
    end_ev(0, 0);
    drain();
    check(!out_valid && q.size() == 0, "R4 empty event adds no word", out_valid, 0);
    send_hw(16'h5A5A); send_hw(16'hA5A5); end_ev(0, 0);
    drain();
    check(!out_valid && q.size() == 0, "R4 even event adds no word", out_valid, 0);

    // R5 odd event then a fresh pair
    cur_tag = "R5 fresh word after close";
    order_sel = 1; fill_sel = 2'b01;
    send_hw(16'h0101); end_ev(0, 0);
    send_hw(16'h0202); send_hw(16'h0303); end_ev(0, 0);

    // R6 configuration changed mid-event
    cur_tag = "R6 config captured";
    order_sel = 1; fill_sel = 2'b10;
    send_hw(16'hBEEF);
    order_sel = 0; fill_sel = 2'b00;
    send_hw(16'hCAFE); send_hw(16'hD00D);
    end_ev(0, 0);

    // R9 halfword together with end_event
    cur_tag = "R9 same-cycle halfword";
    order_sel = 0; fill_sel = 2'b11;
    send_hw(16'h7777); end_ev(1, 16'h8888);
    order_sel = 1; end_ev(1, 16'h9999);
    cur_tag = "";

    // random traffic
    for (int e = 0; e < 400; e++) begin
      int len;
      ready_pct = 30 + ($urandom % 70);
      order_sel = 1'($urandom); fill_sel = 2'($urandom);
      len = $urandom % 8;
      for (int k = 0; k < len; k++) begin
        if (($urandom % 4) == 0) begin
          order_sel = 1'($urandom); fill_sel = 2'($urandom);
        end
        repeat ($urandom % 3) tick();
        send_hw(16'($urandom));
      end
      if (($urandom % 3) == 0) end_ev(1, 16'($urandom));
      else end_ev(0, 0);
    end

    drain();
    check(q.size() == 0 && got_done == exp_done, "R4 all words and done pulses seen",
          got_done, exp_done);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule